// File: doc/BRIEF.md
# Reseedable Walsh-Spectrum Test Pattern Generator

This block drives the inputs of a circuit under test during built-in self test. A free-running Walsh counter provides a family of Walsh waveforms, and each output picks one waveform by a configured index. Before the bit leaves the block, a weighted noise bit taken from a maximal-length LFSR is XORed onto it. The result is a pattern stream whose dominant spectral components follow a known spectrum, with controlled random noise on top.

The generator state is the Walsh counter plus the LFSR. That state can be loaded in one cycle through a parallel port, or shifted in serially one bit per tester strobe while the old state shifts out. In external mode the state never advances, so each loaded seed yields exactly one vector. In hybrid mode the state advances on every pattern tick, and a reseed is only needed occasionally. A programmable hold length stretches each pattern over several system clocks for sequential targets.

Top module: `spec_tpg`

## Requirements
- R1: While reset is asserted, `pat_o` is all zeros and `busy_o` is low.
- R2: With weight code 0, output bit j equals the XOR-reduction of (Walsh counter AND the 4-bit index `sel_i[4j+3:4j]`).
- R3: Weight code 1 XORs LFSR bit (j mod 16) onto output j. Code 2 XORs the AND of LFSR bits (j mod 16) and ((j+8) mod 16). Code 3 XORs the OR of those two bits. The code for input j is `wgt_i[2j+1:2j]`.
- R4: In hybrid mode (`mode_i`=1), every pattern tick advances the counter by one (mod 16) and shifts the LFSR left, with bit 0 taking the XOR of bits 15, 14, 12 and 3.
- R5: In external mode (`mode_i`=0), the state never advances, so every tick repeats the vector of the loaded seed.
- R6: A tick occurs every `hold_len_i`+1 cycles. The first tick comes `hold_len_i`+1 cycles after a load completes, and `pat_o` is stable between ticks. `pat_o` shows the vector of the state that held before that tick's advance.
- R7: A parallel load (`seed_load_i` with `par_sel_i`=1) puts `seed_i[19:16]` into the counter and `seed_i[15:0]` into the LFSR in one cycle.
- R8: `seed_load_i` with `par_sel_i`=0 raises `busy_o` on the next cycle. Each `scan_stb_i` then shifts `scan_si_i` in, MSB of the new seed first. `busy_o` falls in the cycle after the 20th strobe.
- R9: While `busy_o` is high, `pat_o` does not change and the state does not advance.
- R10: `scan_so_o` shows the current MSB of the seed chain, so the old seed leaves MSB first during a serial load.
- R11: `seed_load_i` is ignored while `busy_o` is high.
- R12: A load accepted in a cycle that would otherwise tick takes priority: `pat_o` keeps its value and the hold count restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = autonomous hybrid generation, 0 = one vector per seed |
| hold_len_i | input | 3 | Extra cycles each pattern is held |
| sel_i | input | 32 | Walsh index per output, 4 bits each |
| wgt_i | input | 16 | Noise weight code per output, 2 bits each |
| seed_load_i | input | 1 | Reseed strobe |
| par_sel_i | input | 1 | 1 = parallel load, 0 = serial load |
| seed_i | input | 20 | Parallel seed {counter, LFSR} |
| scan_stb_i | input | 1 | Tester-rate strobe, one serial bit per pulse |
| scan_si_i | input | 1 | Serial seed input |
| scan_so_o | output | 1 | Serial seed output (chain MSB) |
| busy_o | output | 1 | Serial reseed in progress |
| pat_o | output | 8 | Pattern to the circuit under test |

## Verification
The case that matters is a reseed landing in the same cycle as a pattern tick. With a hold length of zero, a tick is due on every edge, so any parallel load collides with one. The bench checks that the output keeps its old vector through that edge and shows the new seed's vector on the next edge. A second pairing is a reseed strobe while a serial shift is active. The bench issues a parallel load in the middle of a serial load, then checks that the final pattern and the shifted-out MSB reflect only the serial seed.

// File: rtl/spec_tpg_pkg.sv
package spec_tpg_pkg;
  typedef enum logic [1:0] {
    WGT_OFF   = 2'd0,
    WGT_HALF  = 2'd1,
    WGT_QUART = 2'd2,
    WGT_3QUAR = 2'd3
  } wgt_e;
endpackage

// File: rtl/spec_walsh_gen.sv
module spec_walsh_gen #(
  parameter int N_IN  = 8,
  parameter int HAD_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_i,
  input  logic [HAD_W-1:0]        ld_val_i,
  input  logic                    shift_i,
  input  logic                    shift_in_i,
  input  logic                    adv_i,
  input  logic [N_IN*HAD_W-1:0]   sel_i,
  output logic                    msb_o,
  output logic [N_IN-1:0]         walsh_o
);
  logic [HAD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (ld_i)    cnt_q <= ld_val_i;
    else if (shift_i) cnt_q <= {cnt_q[HAD_W-2:0], shift_in_i};
    else if (adv_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign msb_o = cnt_q[HAD_W-1];

  for (genvar j = 0; j < N_IN; j++) begin : g_walsh
    // Walsh row index selects which counter bits fold into the parity
    assign walsh_o[j] = ^(cnt_q & sel_i[j*HAD_W +: HAD_W]);
  end
endmodule

// File: rtl/spec_lfsr.sv
module spec_lfsr #(
  parameter int                 LFSR_W  = 16,
  parameter logic [LFSR_W-1:0]  TAPS    = 16'hD008,
  parameter logic [LFSR_W-1:0]  RST_VAL = 16'h0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [LFSR_W-1:0] ld_val_i,
  input  logic              shift_i,
  input  logic              shift_in_i,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] lfsr_o,
  output logic              msb_o
);
  logic [LFSR_W-1:0] q;
  logic              fb;

  assign fb = ^(q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= RST_VAL;
    else if (ld_i)    q <= ld_val_i;
    else if (shift_i) q <= {q[LFSR_W-2:0], shift_in_i};
    else if (adv_i)   q <= {q[LFSR_W-2:0], fb};
  end

  assign lfsr_o = q;
  assign msb_o  = q[LFSR_W-1];
endmodule

// File: rtl/spec_randomizer.sv
module spec_randomizer
  import spec_tpg_pkg::*;
#(
  parameter int N_IN   = 8,
  parameter int LFSR_W = 16
) (
  input  logic [N_IN-1:0]   walsh_i,
  input  logic [LFSR_W-1:0] lfsr_i,
  input  logic [2*N_IN-1:0] wgt_i,
  output logic [N_IN-1:0]   pat_o
);
  for (genvar j = 0; j < N_IN; j++) begin : g_rnd
    localparam int TA = j % LFSR_W;
    localparam int TB = (j + LFSR_W/2) % LFSR_W;
    wgt_e code;
    logic noise;
    assign code = wgt_e'(wgt_i[2*j +: 2]);
    always_comb begin
      unique case (code)
        WGT_HALF:  noise = lfsr_i[TA];
        WGT_QUART: noise = lfsr_i[TA] & lfsr_i[TB];
        WGT_3QUAR: noise = lfsr_i[TA] | lfsr_i[TB];
        default:   noise = 1'b0;
      endcase
    end
    assign pat_o[j] = walsh_i[j] ^ noise;
  end
endmodule

// File: rtl/spec_seed_ctrl.sv
module spec_seed_ctrl #(
  parameter int SEED_W = 20,
  parameter int HOLD_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_load_i,
  input  logic              par_sel_i,
  input  logic              scan_stb_i,
  input  logic [HOLD_W-1:0] hold_len_i,
  output logic              par_ld_o,
  output logic              shift_o,
  output logic              tick_o,
  output logic              busy_o
);
  localparam int CW = $clog2(SEED_W);

  logic              busy_q;
  logic [CW-1:0]     bcnt_q;
  logic [HOLD_W-1:0] div_q;
  logic              accept, ser_start, ser_done;

  assign accept    = seed_load_i & ~busy_q;
  assign par_ld_o  = accept & par_sel_i;
  assign ser_start = accept & ~par_sel_i;
  assign shift_o   = busy_q & scan_stb_i;
  assign ser_done  = shift_o & (bcnt_q == CW'(SEED_W-1));
  // load has priority over a due tick
  assign tick_o    = ~busy_q & ~accept & (div_q >= hold_len_i);
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bcnt_q <= '0;
    end else if (ser_start) begin
      busy_q <= 1'b1;
      bcnt_q <= '0;
    end else if (shift_o) begin
      if (ser_done) busy_q <= 1'b0;
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        div_q <= '0;
    else if (accept | busy_q | tick_o)  div_q <= '0;
    else                                div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/spec_tpg.sv
module spec_tpg #(
  parameter int                 N_IN   = 8,
  parameter int                 HAD_W  = 4,
  parameter int                 LFSR_W = 16,
  parameter int                 HOLD_W = 3,
  parameter logic [LFSR_W-1:0]  TAPS   = 16'hD008,
  localparam int                SEED_W = HAD_W + LFSR_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_i,
  input  logic [HOLD_W-1:0]     hold_len_i,
  input  logic [N_IN*HAD_W-1:0] sel_i,
  input  logic [2*N_IN-1:0]     wgt_i,
  input  logic                  seed_load_i,
  input  logic                  par_sel_i,
  input  logic [SEED_W-1:0]     seed_i,
  input  logic                  scan_stb_i,
  input  logic                  scan_si_i,
  output logic                  scan_so_o,
  output logic                  busy_o,
  output logic [N_IN-1:0]       pat_o
);
  logic              par_ld, shift, tick, adv;
  logic              lfsr_msb;
  logic [LFSR_W-1:0] lfsr;
  logic [N_IN-1:0]   walsh, rnd;
  logic [N_IN-1:0]   pat_q;

  spec_seed_ctrl #(.SEED_W(SEED_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk_i, .rst_ni, .seed_load_i, .par_sel_i, .scan_stb_i, .hold_len_i,
    .par_ld_o(par_ld), .shift_o(shift), .tick_o(tick), .busy_o(busy_o)
  );

  assign adv = tick & mode_i;

  // chain: scan_si -> lfsr -> counter -> scan_so
  spec_lfsr #(.LFSR_W(LFSR_W), .TAPS(TAPS)) u_lfsr (
    .clk_i, .rst_ni,
    .ld_i(par_ld), .ld_val_i(seed_i[LFSR_W-1:0]),
    .shift_i(shift), .shift_in_i(scan_si_i), .adv_i(adv),
    .lfsr_o(lfsr), .msb_o(lfsr_msb)
  );

  spec_walsh_gen #(.N_IN(N_IN), .HAD_W(HAD_W)) u_walsh (
    .clk_i, .rst_ni,
    .ld_i(par_ld), .ld_val_i(seed_i[SEED_W-1 -: HAD_W]),
    .shift_i(shift), .shift_in_i(lfsr_msb), .adv_i(adv),
    .sel_i, .msb_o(scan_so_o), .walsh_o(walsh)
  );

  spec_randomizer #(.N_IN(N_IN), .LFSR_W(LFSR_W)) u_rnd (
    .walsh_i(walsh), .lfsr_i(lfsr), .wgt_i, .pat_o(rnd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pat_q <= '0;
    else if (tick) pat_q <= rnd;
  end

  assign pat_o = pat_q;
endmodule

// File: rtl/spec_tpg_chk.sv
module spec_tpg_chk #(
  parameter int N_IN   = 8,
  parameter int SEED_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seed_load_i,
  input logic              par_sel_i,
  input logic [SEED_W-1:0] seed_i,
  input logic              scan_stb_i,
  input logic              scan_so_o,
  input logic              busy_o,
  input logic [N_IN-1:0]   pat_o
);
  // R1
  always @(posedge clk_i) if (!rst_ni) begin
    reset_state_chk: assert (pat_o == '0 && !busy_o);
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pat_o));

  // R8
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(seed_load_i && !par_sel_i));

  // R8
  busy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !scan_stb_i |=> busy_o);

  // R12
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i && par_sel_i && !busy_o |=> $stable(pat_o));

  // R7
  par_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_load_i && par_sel_i && !busy_o |=> scan_so_o == $past(seed_i[SEED_W-1]));
endmodule

bind spec_tpg spec_tpg_chk #(.N_IN(N_IN), .SEED_W(SEED_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .seed_load_i(seed_load_i),
  .par_sel_i(par_sel_i), .seed_i(seed_i), .scan_stb_i(scan_stb_i),
  .scan_so_o(scan_so_o), .busy_o(busy_o), .pat_o(pat_o)
);

// File: tb/tb_spec_tpg.sv
`timescale 1ns/1ps
module tb_spec_tpg;
  logic        clk_i = 0, rst_ni = 0;
  logic        mode_i = 0;
  logic [2:0]  hold_len_i = 0;
  logic [31:0] sel_i = 0;
  logic [15:0] wgt_i = 0;
  logic        seed_load_i = 0, par_sel_i = 0;
  logic [19:0] seed_i = 0;
  logic        scan_stb_i = 0, scan_si_i = 0;
  logic        scan_so_o, busy_o;
  logic [7:0]  pat_o;

  spec_tpg dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0]  m_cnt;
  logic [15:0] m_lfsr;
  logic [7:0]  prev;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_pat(input logic [3:0] c, input logic [15:0] l,
                                       input logic [31:0] s, input logic [15:0] w);
    logic [7:0] p;
    for (int j = 0; j < 8; j++) begin
      logic wb, a, b, n;
      wb = ^(c & s[j*4 +: 4]);
      a  = l[j % 16];
      b  = l[(j + 8) % 16];
      case (w[2*j +: 2])
        2'd1: n = a;
        2'd2: n = a & b;
        2'd3: n = a | b;
        default: n = 1'b0;
      endcase
      p[j] = wb ^ n;
    end
    return p;
  endfunction

  function automatic logic [15:0] f_step(input logic [15:0] l);
    return {l[14:0], l[15] ^ l[14] ^ l[12] ^ l[3]};
  endfunction

  // called aligned at a negedge
  task automatic par_load(input logic [19:0] s);
    seed_i = s; par_sel_i = 1; seed_load_i = 1;
    @(negedge clk_i);
    seed_load_i = 0;
    m_cnt = s[19:16]; m_lfsr = s[15:0];
  endtask

  task automatic run_vecs(input string req, input int n, input int h);
    logic [7:0] e;
    for (int k = 0; k < n; k++) begin
      if (h > 0) begin
        repeat (h) @(negedge clk_i);
        chk("R6 hold", pat_o, prev);
      end
      @(negedge clk_i);
      e = f_pat(m_cnt, m_lfsr, sel_i, wgt_i);
      chk(req, pat_o, e);
      prev = e;
      if (mode_i) begin
        m_cnt = m_cnt + 1'b1;
        m_lfsr = f_step(m_lfsr);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [19:0] s_old, s_new;
    logic [3:0]  idx [8] = '{4'd2, 4'd3, 4'd1, 4'd1, 4'd1, 4'd0, 4'd15, 4'd8};
    void'($urandom(32'h5EED1));
    prev = 0;
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 pat", pat_o, 0);
    chk("R1 busy", busy_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2 R4 R7: pure Walsh, hybrid, directed indices
    for (int j = 0; j < 8; j++) sel_i[j*4 +: 4] = idx[j];
    wgt_i = 0; mode_i = 1; hold_len_i = 0;
    par_load(20'h3_ACE1);
    run_vecs("R2 R4 R7 walsh", 20, 0);

    // R3 R4 R6: random weights, indices, seeds, hold lengths
    for (int it = 0; it < 6; it++) begin
      sel_i = $urandom; wgt_i = $urandom;
      hold_len_i = 3'($urandom_range(0, 7));
      par_load(20'($urandom) | 20'h1);
      run_vecs("R3 R4 R6 noise", 8, int'(hold_len_i));
    end

    // R3 directed: all-ones LFSR with each code
    sel_i = 0; hold_len_i = 0;
    for (int c = 0; c < 4; c++) begin
      wgt_i = {8{2'(c)}};
      par_load(20'h0_FFFF);
      run_vecs("R3 code", 1, 0);
    end

    // R5: external mode repeats one vector
    mode_i = 0; sel_i = $urandom; wgt_i = $urandom; hold_len_i = 2;
    s_old = 20'h9_1234;
    par_load(s_old);
    run_vecs("R5 ext repeat", 4, 2);

    // R8 R9 R10 R11: serial reseed in external mode
    s_new = 20'hC_BEEF;
    par_sel_i = 0; seed_load_i = 1;
    @(negedge clk_i);
    seed_load_i = 0;
    chk("R8 busy rise", busy_o, 1);
    for (int i = 0; i < 20; i++) begin
      chk("R10 so", scan_so_o, s_old[19 - i]);
      scan_si_i = s_new[19 - i]; scan_stb_i = 1;
      @(negedge clk_i);
      scan_stb_i = 0;
      if (i < 19) begin
        if (i == 10) chk("R8 busy mid", busy_o, 1);
        if (i == 7) begin
          // R11: parallel reseed attempt while busy
          seed_i = 20'h0_0F0F; par_sel_i = 1; seed_load_i = 1;
          @(negedge clk_i);
          seed_load_i = 0;
          repeat (8) @(negedge clk_i);
        end else repeat (9) @(negedge clk_i);
        if (i % 6 == 0) chk("R9 pat held", pat_o, prev);
      end
    end
    chk("R8 busy fall", busy_o, 0);
    chk("R8 R11 so new", scan_so_o, s_new[19]);
    m_cnt = s_new[19:16]; m_lfsr = s_new[15:0];
    run_vecs("R8 R11 serial seed", 2, 2);

    // R12: load collides with a due tick
    mode_i = 1; hold_len_i = 0; sel_i = $urandom; wgt_i = $urandom;
    par_load(20'h5_0A0B);
    run_vecs("R12 pre", 3, 0);
    par_load(20'hE_7777);
    chk("R12 load wins", pat_o, prev);
    run_vecs("R12 post", 3, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule